// File: doc/BRIEF.md
# Watchdog Supervisor with Coupled System Reset

This block supervises a processor by counting system clock cycles between kick pulses. If no kick arrives within a programmed number of cycles, it pulls its active-low watchdog output low. When reset coupling is enabled, an expiry also drives the active-low system reset for a programmed number of cycles. That reset then clears the watchdog, so the watchdog output shows only a short pulse of fixed width. A sticky flag records that a watchdog expiry caused a reset. It stays set until a dedicated clear pulse.

An enable input also requests the system reset while it is low. In the default (dependent) mode, any active system reset holds the watchdog cleared. In independent mode, a reset caused by the enable input leaves the watchdog counting. Independent mode also supports a 3-bit startup-delay code: code 0 gives no delay, and code k gives DLY_BASE·2^(k-1) cycles. The delay runs after the boot-complete input rises and before the first timeout window opens.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain level control or status signal, and back-pressure does not apply.

Top module: `wdt_supervisor`

## Requirements
- R1: After rst_n is released, wdo_n reads 1, sys_rst_n reads 1 and wd_reset_flag reads 0.
- R2: While running, each kick sampled high reloads the window. If no kick is sampled for cfg_timeout consecutive edges after a reload (a value of 0 acts as 1), wdo_n goes low after the cfg_timeout-th edge. On entry from boot, expiry follows the (delay+cfg_timeout+1)-th edge after boot_done is first sampled high.
- R3: With cfg_rst_couple=0, an expiry leaves sys_rst_n high and wd_reset_flag at 0. wdo_n stays low until a kick is sampled, and returns high after that edge.
- R4: With cfg_rst_couple=1, sys_rst_n goes low one edge after wdo_n falls, and wdo_n returns high one edge after that. wdo_n is therefore low for exactly 2 cycles.
- R5: A watchdog-caused reset holds sys_rst_n low for exactly cfg_rst_period cycles. A value of 0 acts as 1.
- R6: wd_reset_flag is set on the edge a watchdog expiry requests reset. It stays 1 until wdr_clear is sampled high. A reset caused by en_in does not set it.
- R7: When en_in is sampled low, sys_rst_n is low after that edge and returns high cfg_rst_period edges after the last edge that sampled en_in low. In dependent mode (cfg_indep=0), this releases a low wdo_n one edge after sys_rst_n falls.
- R8: In independent mode (cfg_indep=1), a reset caused by en_in does not release wdo_n or reload the watchdog counter.
- R9: In independent mode, code k of cfg_delay_code delays arming by 0 cycles for k=0 and by DLY_BASE·2^(k-1) cycles otherwise. Kicks are ignored during the delay. In dependent mode the code is ignored.
- R10: While boot_done is low, the watchdog is idle and wdo_n stays 1.
- R11: Kicks are ignored while sys_rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| boot_done | input | 1 | High once power-up and boot are complete |
| en_in | input | 1 | Low requests a system reset |
| kick | input | 1 | One-cycle watchdog service pulse |
| wdr_clear | input | 1 | Write-one-to-clear for wd_reset_flag |
| cfg_rst_couple | input | 1 | 1: expiry also drives sys_rst_n |
| cfg_indep | input | 1 | 1: independent watchdog mode |
| cfg_delay_code | input | 3 | Startup-delay code (independent mode) |
| cfg_timeout | input | TW | Timeout window in cycles |
| cfg_rst_period | input | TW | Reset pulse length in cycles |
| wdo_n | output | 1 | Watchdog output, active low |
| sys_rst_n | output | 1 | System reset output, active low |
| wd_reset_flag | output | 1 | Sticky: last reset came from the watchdog |

## Verification
Every output is driven from a register, so each result appears after a fixed edge. wdo_n falls after the (delay+timeout+1)-th edge following boot, or the timeout-th edge after the last kick. sys_rst_n follows one edge later, and wdo_n rises one edge after that. The reset then lasts the period in cycles, and a kick or clear takes effect on the edge that samples it. The bench drives inputs and samples outputs on falling edges and counts rising edges between the two. Each expected count is taken from these rules and compared exactly, never within a range.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    PH_BOOT,    // waiting for boot completion
    PH_DELAY,   // startup delay, kicks ignored
    PH_RUN,     // timeout window open
    PH_EXP,     // expired, no reset coupling
    PH_PULSE,   // expired, reset being requested
    PH_PULSE2,  // reset asserted, output still low
    PH_HOLD     // held cleared by system reset
  } wd_phase_e;
endpackage

// File: rtl/wdt_delay_lut.sv
module wdt_delay_lut #(
  parameter int TW       = 16,
  parameter int CODE_W   = 3,
  parameter int DLY_BASE = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [TW-1:0]     cycles
);
  localparam int NCODES = 2 ** CODE_W;

  logic [TW-1:0] tbl [NCODES];

  for (genvar k = 0; k < NCODES; k++) begin : g_ent
    if (k == 0) begin : g_zero
      assign tbl[k] = '0;
    end else begin : g_pow
      assign tbl[k] = TW'(DLY_BASE) << (k - 1);
    end
  end

  assign cycles = tbl[code];
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_done,
  input  logic          kick_eff,
  input  logic          hold,
  input  logic          couple,
  input  logic          indep,
  input  logic [TW-1:0] timeout,
  input  logic [TW-1:0] delay_cycles,
  output logic          wdo_n,
  output logic          wd_req
);
  wd_phase_e     phase;
  logic [TW-1:0] cnt;
  logic [TW-1:0] tmo_eff;

  assign tmo_eff = (timeout == '0) ? TW'(1) : timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_BOOT;
      cnt   <= '0;
    end else if (!boot_done) begin
      phase <= PH_BOOT;
      cnt   <= '0;
    end else if (hold) begin
      phase <= PH_HOLD;
      cnt   <= tmo_eff;
    end else begin
      case (phase)
        PH_BOOT: begin
          if (indep && delay_cycles != '0) begin
            phase <= PH_DELAY;
            cnt   <= delay_cycles;
          end else begin
            phase <= PH_RUN;
            cnt   <= tmo_eff;
          end
        end
        PH_DELAY: begin
          if (cnt <= TW'(1)) begin
            phase <= PH_RUN;
            cnt   <= tmo_eff;
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
        PH_RUN: begin
          if (kick_eff) begin
            cnt <= tmo_eff;
          end else if (cnt <= TW'(1)) begin
            phase <= couple ? PH_PULSE : PH_EXP;
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
        PH_EXP: begin
          if (kick_eff) begin
            phase <= PH_RUN;
            cnt   <= tmo_eff;
          end
        end
        PH_PULSE:  phase <= PH_PULSE2;
        PH_PULSE2: phase <= PH_HOLD;
        PH_HOLD: begin
          phase <= PH_RUN;
          cnt   <= tmo_eff;
        end
        default: phase <= PH_BOOT;
      endcase
    end
  end

  assign wd_req = (phase == PH_PULSE);
  assign wdo_n  = !(phase == PH_EXP || phase == PH_PULSE || phase == PH_PULSE2);
endmodule

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_in,
  input  logic          wd_req,
  input  logic          wdr_clear,
  input  logic [TW-1:0] period,
  output logic          rst_active,
  output logic          cause_wd,
  output logic          wd_flag
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] per_eff;

  assign per_eff = (period == '0) ? TW'(1) : period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cause_wd <= 1'b0;
    end else if (!en_in) begin
      cnt      <= per_eff;
      cause_wd <= 1'b0;
    end else if (wd_req) begin
      cnt      <= per_eff;
      cause_wd <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wd_flag <= 1'b0;
    else if (wd_req)    wd_flag <= 1'b1;
    else if (wdr_clear) wd_flag <= 1'b0;
  end

  assign rst_active = (cnt != '0);
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int TW       = 16,
  parameter int DLY_BASE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_done,
  input  logic          en_in,
  input  logic          kick,
  input  logic          wdr_clear,
  input  logic          cfg_rst_couple,
  input  logic          cfg_indep,
  input  logic [2:0]    cfg_delay_code,
  input  logic [TW-1:0] cfg_timeout,
  input  logic [TW-1:0] cfg_rst_period,
  output logic          wdo_n,
  output logic          sys_rst_n,
  output logic          wd_reset_flag
);
  localparam int CODE_W = 3;

  logic [TW-1:0] delay_cycles;
  logic          rst_active;
  logic          cause_wd;
  logic          wd_req;
  logic          hold;
  logic          kick_eff;

  wdt_delay_lut #(.TW(TW), .CODE_W(CODE_W), .DLY_BASE(DLY_BASE)) u_lut (
    .code   (cfg_delay_code),
    .cycles (delay_cycles)
  );

  // Watchdog is held cleared by its own reset, or by any reset when dependent.
  assign hold     = rst_active && (!cfg_indep || cause_wd);
  assign kick_eff = kick && !rst_active;

  wdt_timer #(.TW(TW)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_done    (boot_done),
    .kick_eff     (kick_eff),
    .hold         (hold),
    .couple       (cfg_rst_couple),
    .indep        (cfg_indep),
    .timeout      (cfg_timeout),
    .delay_cycles (delay_cycles),
    .wdo_n        (wdo_n),
    .wd_req       (wd_req)
  );

  wdt_reset_gen #(.TW(TW)) u_rstgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_in      (en_in),
    .wd_req     (wd_req),
    .wdr_clear  (wdr_clear),
    .period     (cfg_rst_period),
    .rst_active (rst_active),
    .cause_wd   (cause_wd),
    .wd_flag    (wd_reset_flag)
  );

  assign sys_rst_n = !rst_active;
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic boot_done,
  input logic en_in,
  input logic wdr_clear,
  input logic cfg_rst_couple,
  input logic wdo_n,
  input logic sys_rst_n,
  input logic wd_reset_flag
);
  // R4: coupled expiry asserts reset on the next edge
  p_rst_follows_wdo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wdo_n) && cfg_rst_couple && sys_rst_n && boot_done && en_in) |=> !sys_rst_n);

  // R4: wdo released one edge after coupled reset asserts
  p_wdo_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n && $fell(sys_rst_n) && cfg_rst_couple && boot_done) |=> wdo_n);

  // R6: flag is sticky until cleared
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_reset_flag && !wdr_clear) |=> wd_reset_flag);

  // R6: flag rises together with an asserted reset
  p_flag_with_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset_flag) |-> !sys_rst_n);

  // R3: without coupling, reset only follows en_in
  p_no_couple_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rst_couple && en_in && sys_rst_n) |=> sys_rst_n);

  // R10: idle before boot completes
  p_boot_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |=> wdo_n);
endmodule

bind wdt_supervisor wdt_supervisor_chk u_chk (.*);

// File: tb/wdt_supervisor_bench.sv
`timescale 1ns/1ps
module wdt_supervisor_bench;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n, boot_done, en_in, kick, wdr_clear;
  logic cfg_rst_couple, cfg_indep;
  logic [2:0] cfg_delay_code;
  logic [TW-1:0] cfg_timeout, cfg_rst_period;
  logic wdo_n, sys_rst_n, wd_reset_flag;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  wdt_supervisor #(.TW(TW), .DLY_BASE(4)) u_wdt_supervisor (.*);

  typedef struct packed {
    logic        couple;
    logic        indep;
    logic [2:0]  code;
    logic [15:0] tmo;
    logic [15:0] per;
    logic [15:0] exp_n;   // edges from boot to wdo_n low = delay+timeout+1
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b1, 1'b0, 3'd0, 16'd5, 16'd3, 16'd6},
    '{1'b0, 1'b0, 3'd3, 16'd4, 16'd3, 16'd5},    // dependent: code ignored
    '{1'b1, 1'b1, 3'd0, 16'd7, 16'd4, 16'd8},
    '{1'b1, 1'b1, 3'd2, 16'd3, 16'd2, 16'd12},   // delay 8
    '{1'b0, 1'b1, 3'd1, 16'd6, 16'd2, 16'd11},   // delay 4
    '{1'b1, 1'b1, 3'd7, 16'd2, 16'd5, 16'd259},  // delay 256
    '{1'b1, 1'b0, 3'd0, 16'd3, 16'd0, 16'd4}     // period 0 acts as 1
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; boot_done = 1'b0; en_in = 1'b1; kick = 1'b0; wdr_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic count_to_wdo(output int n);
    n = 0;
    while (wdo_n && n < 2000) begin step(); n++; end
  endtask

  task automatic count_rst_low(output int n);
    n = 0;
    while (!sys_rst_n && n < 2000) begin step(); n++; end
  endtask

  task automatic set_cfg(input logic c, input logic i, input logic [2:0] d,
                         input logic [15:0] t, input logic [15:0] p);
    cfg_rst_couple = c; cfg_indep = i; cfg_delay_code = d;
    cfg_timeout = t; cfg_rst_period = p;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(4.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    set_cfg(1'b0, 1'b0, 3'd0, 16'd5, 16'd3);
    do_reset();
    // R1 reset state
    chk("R1 wdo_n", wdo_n, 1);
    chk("R1 sys_rst_n", sys_rst_n, 1);
    chk("R1 flag", wd_reset_flag, 0);

    // R10 idle without boot
    repeat (50) step();
    chk("R10 wdo_n before boot", wdo_n, 1);

    // Vector walk: R2 R9 expiry timing, R3/R4/R5/R6 outcomes
    for (int v = 0; v < 7; v++) begin
      set_cfg(VEC[v].couple, VEC[v].indep, VEC[v].code, VEC[v].tmo, VEC[v].per);
      do_reset();
      boot_done = 1'b1;
      count_to_wdo(n);
      chk($sformatf("R2/R9 expiry edges vec%0d", v), n, int'(VEC[v].exp_n));
      if (VEC[v].couple) begin
        step();
        chk("R4 reset one edge after wdo", sys_rst_n, 0);
        chk("R4 wdo still low", wdo_n, 0);
        step();
        chk("R4 wdo released", wdo_n, 1);
        count_rst_low(n);
        chk("R5 reset width", n + 1, (VEC[v].per == 0) ? 1 : int'(VEC[v].per));
        chk("R6 flag set", wd_reset_flag, 1);
      end else begin
        repeat (4) step();
        chk("R3 wdo held low", wdo_n, 0);
        chk("R3 reset unaffected", sys_rst_n, 1);
        chk("R6 flag clear without coupling", wd_reset_flag, 0);
        kick = 1'b1; step(); kick = 1'b0;
        chk("R3 kick releases wdo", wdo_n, 1);
      end
    end

    // R2 periodic kicks keep wdo high, then expiry after timeout edges
    set_cfg(1'b0, 1'b0, 3'd0, 16'd5, 16'd3);
    do_reset();
    boot_done = 1'b1;
    for (int i = 0; i < 8; i++) begin
      repeat (2) step();
      kick = 1'b1; step(); kick = 1'b0;
    end
    chk("R2 kicked wdo high", wdo_n, 1);
    count_to_wdo(n);
    chk("R2 expiry after last kick", n, 5);

    // R9 kicks ignored during startup delay (delay 8, timeout 3 -> 12 edges)
    set_cfg(1'b0, 1'b1, 3'd2, 16'd3, 16'd3);
    do_reset();
    boot_done = 1'b1;
    kick = 1'b1;
    repeat (6) step();
    kick = 1'b0;
    count_to_wdo(n);
    chk("R9 kicks ignored in delay", n + 6, 12);

    // R7 dependent: en_in reset releases wdo and lasts period
    set_cfg(1'b0, 1'b0, 3'd0, 16'd4, 16'd3);
    do_reset();
    boot_done = 1'b1;
    count_to_wdo(n);
    en_in = 1'b0; step();
    chk("R7 en reset asserted", sys_rst_n, 0);
    en_in = 1'b1; step();
    chk("R7 dependent wdo released", wdo_n, 1);
    count_rst_low(n);
    chk("R7 en reset width", n + 1, 3);
    chk("R6 en reset leaves flag", wd_reset_flag, 0);

    // R8 independent: en_in reset leaves wdo low
    set_cfg(1'b0, 1'b1, 3'd0, 16'd4, 16'd3);
    do_reset();
    boot_done = 1'b1;
    count_to_wdo(n);
    en_in = 1'b0;
    repeat (3) step();
    chk("R8 reset active", sys_rst_n, 0);
    chk("R8 wdo unaffected", wdo_n, 0);
    en_in = 1'b1;

    // R11 kicks ignored while reset low (independent, en held low)
    set_cfg(1'b0, 1'b1, 3'd0, 16'd6, 16'd3);
    do_reset();
    en_in = 1'b0;
    boot_done = 1'b1;
    kick = 1'b1;
    count_to_wdo(n);
    chk("R11 kicks ignored in reset", n, 7);
    kick = 1'b0; en_in = 1'b1;

    // R6 flag sticky after reset ends, cleared only by wdr_clear
    set_cfg(1'b1, 1'b0, 3'd0, 16'd20, 16'd2);
    do_reset();
    boot_done = 1'b1;
    count_to_wdo(n);
    repeat (6) step();
    chk("R6 reset released", sys_rst_n, 1);
    chk("R6 flag sticky", wd_reset_flag, 1);
    wdr_clear = 1'b1; step(); wdr_clear = 1'b0;
    chk("R6 flag cleared", wd_reset_flag, 0);

    finish_run();
  end
endmodule